// File: doc/BRIEF.md
# Microsecond Timebase and Line Pulse Filter

This block turns the host bus clock into a one-microsecond timing reference. An integer divider, loaded with the host clock rate in MHz, emits a single-cycle tick once per microsecond. A free-running counter advances by one on each tick, so the host can read elapsed time in microseconds.

The same block also cleans up a raw serial-line level before it reaches the protocol decoder. The line passes through a two-flop synchronizer. A width filter then lets a new level through only after the level has been held for a programmed number of host-clock cycles. Shorter glitches never reach the filtered output. The width is meant to be chosen so that width times clock period lands between 0.4 µs and 0.6 µs; for example, 24 cycles at 50 MHz gives 480 ns.

Top module: `usec_timebase`

## Requirements
- R1: With a divider value D of 2 or more, `tick` is a one-cycle pulse that repeats every D clock cycles.
- R2: A divider value of 0 or 1 makes `tick` high on every clock cycle.
- R3: `usec_count` increases by exactly one in the cycle after each `tick` pulse and holds its value in every other cycle.
- R4: `usec_count` wraps from all ones to zero. Its width is the parameter CNT_W, which defaults to 32.
- R5: The effective filter width is `filt_width` rounded down to a multiple of 8. It is then limited to the range 8 to 88 cycles, so values 0 to 7 give 8 and values above 88 give 88.
- R6: `line_filt` takes a new level only after the synchronized line has differed from it for W consecutive cycles, where W is the effective width. The change appears W+2 clocks after the raw line changes, and shorter pulses are dropped.
- R7: A synchronous active-high `rst` clears `tick`, `usec_count`, `line_filt` and the synchronizer to 0.
- R8: If the divider value is lowered below the current phase of the count, `tick` fires on the next clock and the new period applies from then on.
- R9: If the filter width is lowered below the run already counted, the pending level is committed on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst | input | 1 | Synchronous active-high reset |
| div_val | input | DIV_W | Host clock rate in MHz (integer divider) |
| filt_width | input | FW_W | Minimum pulse width in host-clock cycles |
| line_raw | input | 1 | Asynchronous raw line level |
| tick | output | 1 | One-cycle 1 MHz pulse |
| usec_count | output | CNT_W | Free-running microsecond count |
| line_filt | output | 1 | Width-filtered line level |

## Verification
Two kinds of same-cycle conflict are provoked deliberately. The first is a counter wrap that lands on a tick arriving every cycle: the divider is set to 0 and the bench is built with a narrow counter, so wraps come quickly. The second is a control change that arrives in the middle of a running count: the divider is lowered in the middle of a long period, and the filter width is cut while a level change is still being counted. In both cases the behavioural model in the bench predicts the cycle of the next tick or commit, and every output is compared against it on every clock. Directed checks then measure the tick period, the filter latency at the clamped widths and the rejection of a short glitch.

// File: rtl/usec_timebase_pkg.sv
package usec_timebase_pkg;
  localparam int FILT_MIN  = 8;
  localparam int FILT_MAX  = 88;
  localparam int FILT_LSBS = 3;  // widths are multiples of 2**FILT_LSBS
  localparam int RUN_W     = $clog2(FILT_MAX + 1);
endpackage

// File: rtl/usec_tick_div.sv
module usec_tick_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] phase;
  logic [DIV_W-1:0] last_phase;

  always_comb last_phase = (div_val <= DIV_W'(1)) ? '0 : div_val - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= '0;
      tick  <= 1'b0;
    end else if (phase >= last_phase) begin
      phase <= '0;
      tick  <= 1'b1;
    end else begin
      phase <= phase + DIV_W'(1);
      tick  <= 1'b0;
    end
  end

  AST_TICK_EVERY_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (div_val <= DIV_W'(1)) |=> tick); // R2
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (tick && div_val > DIV_W'(1)) |=> !tick); // R1
endmodule

// File: rtl/usec_counter.sv
module usec_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)       count <= '0;
    else if (tick) count <= count + CNT_W'(1);
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(count)); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '1) |=> (count == '0)); // R4
endmodule

// File: rtl/usec_line_filter.sv
module usec_line_filter
  import usec_timebase_pkg::*;
#(
  parameter int FW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [FW_W-1:0] filt_width,
  input  logic            line_raw,
  output logic            line_filt
);
  logic             s_meta, s_line;
  logic [FW_W-1:0]  rounded;
  logic [RUN_W-1:0] eff_w, run, run_nxt;

  always_comb begin
    rounded = filt_width & ~FW_W'((1 << FILT_LSBS) - 1);
    if (rounded < FW_W'(FILT_MIN))      eff_w = RUN_W'(FILT_MIN);
    else if (rounded > FW_W'(FILT_MAX)) eff_w = RUN_W'(FILT_MAX);
    else                                eff_w = RUN_W'(rounded);
    run_nxt = run + RUN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_meta    <= 1'b0;
      s_line    <= 1'b0;
      run       <= '0;
      line_filt <= 1'b0;
    end else begin
      s_meta <= line_raw;
      s_line <= s_meta;
      if (s_line == line_filt) begin
        run <= '0;
      end else if (run_nxt >= eff_w) begin
        line_filt <= s_line;
        run       <= '0;
      end else begin
        run <= run_nxt;
      end
    end
  end

  always @(posedge clk)
    if (!rst)
      AST_WIDTH_LEGAL: assert (eff_w >= RUN_W'(FILT_MIN) && eff_w <= RUN_W'(FILT_MAX)
                               && eff_w[FILT_LSBS-1:0] == '0); // R5
  AST_HOLD_WHEN_MATCH: assert property (@(posedge clk) disable iff (rst)
    (s_line == line_filt) |=> $stable(line_filt)); // R6
endmodule

// File: rtl/usec_timebase.sv
module usec_timebase #(
  parameter int DIV_W = 8,
  parameter int FW_W  = 8,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  input  logic [FW_W-1:0]  filt_width,
  input  logic             line_raw,
  output logic             tick,
  output logic [CNT_W-1:0] usec_count,
  output logic             line_filt
);
  usec_tick_div #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst(rst), .div_val(div_val), .tick(tick));

  usec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .count(usec_count));

  usec_line_filter #(.FW_W(FW_W)) u_filt (
    .clk(clk), .rst(rst), .filt_width(filt_width),
    .line_raw(line_raw), .line_filt(line_filt));

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!tick && usec_count == '0 && !line_filt)); // R7
endmodule

// File: tb/test_usec_timebase.sv
module test_usec_timebase;
  localparam int CW = 8;
  logic clk = 0, rst = 1, line_raw = 0;
  logic [7:0] div_val = 8'd0, filt_width = 8'd24;
  logic tick, line_filt;
  logic [CW-1:0] usec_count;
  int checks = 0, fails = 0;
  bit done = 0;

  usec_timebase #(.DIV_W(8), .FW_W(8), .CNT_W(CW)) i_usec_timebase (
    .clk(clk), .rst(rst), .div_val(div_val), .filt_width(filt_width),
    .line_raw(line_raw), .tick(tick), .usec_count(usec_count), .line_filt(line_filt));

  always #5 clk = ~clk;

  // behavioural reference model
  int m_phase, m_us, m_run;
  bit m_tick, m_s1, m_s2, m_out;
  always @(posedge clk) begin
    int d, w;
    if (rst) begin
      m_phase = 0; m_tick = 0; m_us = 0; m_run = 0; m_s1 = 0; m_s2 = 0; m_out = 0;
    end else begin
      m_us = (m_us + (m_tick ? 1 : 0)) % (1 << CW);
      d = (div_val < 2) ? 1 : int'(div_val);
      if (m_phase + 1 >= d) begin m_phase = 0; m_tick = 1; end
      else begin m_phase++; m_tick = 0; end
      w = (int'(filt_width) / 8) * 8;
      if (w < 8) w = 8;
      if (w > 88) w = 88;
      if (m_s2 == m_out) m_run = 0;
      else if (m_run + 1 >= w) begin m_out = m_s2; m_run = 0; end
      else m_run++;
      m_s2 = m_s1; m_s1 = line_raw;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    check("R1 R2 R8 tick", tick, m_tick);
    check("R3 R4 usec_count", usec_count, m_us);
    check("R5 R6 R9 line_filt", line_filt, m_out);
  end

  task automatic cyc(int n); repeat (n) @(negedge clk); endtask

  task automatic latency(string tag, bit lvl, int exp);
    int n = 0;
    line_raw = lvl;
    do begin @(negedge clk); n++; end while (line_filt != lvl && n < 200);
    check(tag, n, exp);
  endtask

  initial begin
    cyc(4);
    check("R7 reset tick", tick, 0);
    check("R7 reset count", usec_count, 0);
    check("R7 reset filt", line_filt, 0);
    rst = 0;
    // R2 + R4: tick every cycle, counter wraps
    begin
      bit wrapped = 0;
      int prev = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (prev == (1 << CW) - 1 && usec_count == 0) wrapped = 1;
        prev = usec_count;
      end
      check("R4 wrap seen", wrapped, 1);
    end
    div_val = 8'd1; cyc(5);
    check("R2 div1 tick", tick, 1);
    // R1: period 5
    div_val = 8'd5; cyc(12);
    while (!tick) @(negedge clk);
    begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!tick && n < 100);
      check("R1 period", n, 5);
    end
    // R8: lower divider mid-period
    div_val = 8'd75; cyc(2);
    while (!tick) @(negedge clk);
    cyc(40);
    div_val = 8'd3; cyc(1);
    check("R8 early tick", tick, 1);
    cyc(20);
    // R6: short glitch dropped
    filt_width = 8'd24;
    begin
      bit seen = 0;
      line_raw = 1;
      for (int i = 0; i < 20; i++) begin @(negedge clk); if (line_filt) seen = 1; end
      line_raw = 0;
      for (int i = 0; i < 40; i++) begin @(negedge clk); if (line_filt) seen = 1; end
      check("R6 glitch dropped", seen, 0);
    end
    latency("R6 latency w24", 1, 26);
    filt_width = 8'd3;
    latency("R5 min clamp", 0, 10);
    filt_width = 8'd200;
    latency("R5 max clamp", 1, 90);
    filt_width = 8'd47;
    latency("R5 round down", 0, 42);
    // R9: width lowered mid-run
    filt_width = 8'd88; line_raw = 1; cyc(30);
    check("R9 still low", line_filt, 0);
    filt_width = 8'd8; cyc(1);
    check("R9 early commit", line_filt, 1);
    cyc(10);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule